// File: doc/BRIEF.md
# Crossbar-Routed Logic Cluster

This block is a programmable logic cluster. It holds a row of logic elements, each a small lookup table followed by a flip-flop, with a per-element bit choosing whether the element presents its registered or its combinational value. A full crosspoint fabric sits in front of the elements. Every element input pin has one configuration bit for each possible source, and the sources are the cluster inputs and the element feedback values. One source can therefore fan out to any number of pins at once, and no multiplexer select state exists apart from those crosspoint bits.

All configuration lives in one serial shift chain: the bypass bits, the truth tables and the crosspoint bits. The chain is loaded one bit per clock while the load enable is high. The loaded image survives reset, and reset clears only the element flip-flops. A pin that has no source reads as 0. A pin with several sources also reads as 0 and raises its own conflict flag, so that a bad image shows up at once.

Top module: `clu_cluster`

## Requirements
- R1: Each element computes a 2^K-entry truth table. The pins form address a, with pin p giving bit p. The output bit is the stored bit at table position a XOR (a >> 1), which is the Gray-coded position of the address.
- R2: The configuration chain is W = N + N*2^K + N*K*(I+N) bits long. Bit e is element e's bypass bit. Bit N + e*2^K + g is table position g of element e. Bit N + N*2^K + (e*K+p)*(I+N) + s is the crosspoint joining source s to pin p of element e. While cfg_en is high, the chain shifts toward the MSB once per clock and cfg_din enters bit 0, so the image is sent MSB first.
- R3: While cfg_en is high, clu_out is all zero and every element flip-flop is cleared at each clock edge.
- R4: Sources 0..I-1 are clu_in[0..I-1], and sources I..I+N-1 are elements 0..N-1. A pin with exactly one enabled crosspoint takes that source's value. One source may drive any number of pins in the same cycle.
- R5: A pin with no enabled crosspoint reads as 0.
- R6: A pin with two or more enabled crosspoints reads as 0, and xbar_conflict[e*K+p] is 1. The flag is 0 otherwise.
- R7: With bypass bit 1, the element output follows the table combinationally. With bypass bit 0, it shows the flip-flop, which takes the table value at each rising edge.
- R8: The feedback source of an element carries its flip-flop value, whatever its bypass bit.
- R9: A high rst at a rising edge clears every element flip-flop and leaves the configuration image unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the element flip-flops, active high |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| clu_in | input | I (22) | Cluster inputs |
| clu_out | output | N (10) | Element outputs leaving the cluster |
| xbar_conflict | output | N*K (40) | Per-pin flag for more than one enabled crosspoint |

## Verification
Three configuration images are loaded, and random cluster inputs are applied to each.

- **Clean image:** every pin has exactly one random source. This separates the Gray table ordering and the source numbering from any wrong mapping.
- **Mixed image:** some pins are left open and some have two sources. This tells the zero value of an open pin apart from the zero value forced by a conflict, and checks the conflict flags.
- **Directed image:** one cluster input is fanned out to many pins, and elements feed each other in a ring. This separates registered feedback from combinational feedback.

Each image is also tested with a reset in the middle of the run. If the image were lost at reset, the outputs that follow would go wrong.

// File: rtl/clu_pkg.sv
package clu_pkg;

  // Gray position of a truth-table address
  function automatic int unsigned gray_of(input int unsigned a);
    return a ^ (a >> 1);
  endfunction

  // Chain offset of element e's truth table
  function automatic int unsigned lut_base(input int unsigned n_elem,
                                           input int unsigned depth,
                                           input int unsigned e);
    return n_elem + e * depth;
  endfunction

  // Chain offset of the crosspoint row for sink t
  function automatic int unsigned xp_base(input int unsigned n_elem,
                                          input int unsigned depth,
                                          input int unsigned n_src,
                                          input int unsigned t);
    return n_elem + n_elem * depth + t * n_src;
  endfunction

endpackage

// File: rtl/clu_cfg_chain.sv
module clu_cfg_chain #(
  parameter int W = 1450
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_en,
  input  logic         cfg_din,
  output logic [W-1:0] image
);

  always_ff @(posedge clk) begin
    if (cfg_en) image <= {image[W-2:0], cfg_din};
  end

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> image[0] == $past(cfg_din));

  // R9
  hold_image_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(image));

endmodule

// File: rtl/clu_xbar.sv
module clu_xbar #(
  parameter int S = 32,
  parameter int T = 40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [S-1:0]   src,
  input  logic [T*S-1:0] xp,
  output logic [T-1:0]   sink,
  output logic [T-1:0]   conflict
);

  localparam int CW = $clog2(S + 1);

  for (genvar t = 0; t < T; t++) begin : g_sink
    logic [S-1:0]  row;
    logic [CW-1:0] hits;
    logic          single;

    assign row         = xp[t*S +: S];
    assign hits        = CW'($countones(row));
    assign single      = (hits == CW'(1));
    assign sink[t]     = single & (|(row & src));
    assign conflict[t] = (hits > CW'(1));

    // R6
    multi_zero_chk: assert property (@(posedge clk) disable iff (rst)
      conflict[t] |-> !sink[t]);

    // R5
    open_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (row == '0) |-> (!sink[t] && !conflict[t]));
  end

endmodule

// File: rtl/clu_ble.sv
module clu_ble #(
  parameter int K = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic [K-1:0]      pins,
  input  logic [(1<<K)-1:0] table_bits,
  input  logic              bypass,
  output logic              q_o,
  output logic              out_o
);

  logic [K-1:0] gidx;
  logic         lut_val;

  assign gidx    = K'(clu_pkg::gray_of(int'(pins)));
  assign lut_val = table_bits[gidx];

  always_ff @(posedge clk) begin
    if (rst || cfg_en) q_o <= 1'b0;
    else               q_o <= lut_val;
  end

  assign out_o = cfg_en ? 1'b0 : (bypass ? lut_val : q_o);

  // R7
  reg_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfg_en)) |-> q_o == $past(lut_val));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !q_o);

endmodule

// File: rtl/clu_cluster.sv
module clu_cluster #(
  parameter int K = 4,
  parameter int N = 10,
  parameter int I = 22
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_en,
  input  logic           cfg_din,
  input  logic [I-1:0]   clu_in,
  output logic [N-1:0]   clu_out,
  output logic [N*K-1:0] xbar_conflict
);

  localparam int D   = 1 << K;
  localparam int S   = I + N;
  localparam int T   = N * K;
  localparam int W   = N + N * D + T * S;
  localparam int XPO = clu_pkg::xp_base(N, D, S, 0);

  logic [W-1:0] image;
  logic [N-1:0] q_vec;
  logic [T-1:0] sink;

  clu_cfg_chain #(.W(W)) u_chain (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .image(image)
  );

  clu_xbar #(.S(S), .T(T)) u_xbar (
    .clk(clk), .rst(rst), .src({q_vec, clu_in}),
    .xp(image[XPO +: T*S]), .sink(sink), .conflict(xbar_conflict)
  );

  for (genvar e = 0; e < N; e++) begin : g_elem
    localparam int LO = clu_pkg::lut_base(N, D, e);
    clu_ble #(.K(K)) u_ble (
      .clk(clk), .rst(rst), .cfg_en(cfg_en),
      .pins(sink[e*K +: K]), .table_bits(image[LO +: D]),
      .bypass(image[e]), .q_o(q_vec[e]), .out_o(clu_out[e])
    );
  end

  // R3
  load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> clu_out == '0);

endmodule

// File: tb/tb_clu_cluster.sv
module tb_clu_cluster;
  localparam int CLK_NS = 10;
  localparam int K = 4, N = 10, I = 22;
  localparam int S = I + N, T = N * K, D = 1 << K;
  localparam int W = N + N * D + T * S;
  localparam int XPO = N + N * D;

  logic clk = 0, rst = 1, cfg_en = 1, cfg_din = 0;
  logic [I-1:0] clu_in = '0;
  logic [N-1:0] clu_out;
  logic [T-1:0] xbar_conflict;

  always #(CLK_NS/2) clk = ~clk;

  clu_cluster #(.K(K), .N(N), .I(I)) dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .clu_in(clu_in), .clu_out(clu_out), .xbar_conflict(xbar_conflict)
  );

  int checks = 0, errors = 0;
  logic [D-1:0] tbl [N];
  logic [S-1:0] rowm [T];
  logic [N-1:0] byp, q_m;
  logic [W-1:0] img;
  logic         was_rst;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic src_val(input int s);
    return (s < I) ? clu_in[s] : q_m[s - I];
  endfunction

  function automatic void model(output logic [N-1:0] lv, output logic [T-1:0] cf);
    for (int e = 0; e < N; e++) begin
      logic [K-1:0] addr;
      addr = '0;
      for (int p = 0; p < K; p++) begin
        int hits; logic v;
        hits = 0; v = 0;
        for (int s = 0; s < S; s++)
          if (rowm[e*K+p][s]) begin hits++; v = src_val(s); end
        cf[e*K+p] = (hits > 1);
        addr[p] = (hits == 1) ? v : 1'b0;
      end
      lv[e] = tbl[e][addr];
    end
  endfunction

  function automatic void build_img();
    img = '0;
    for (int e = 0; e < N; e++) begin
      img[e] = byp[e];
      for (int a = 0; a < D; a++) img[N + e*D + (a ^ (a >> 1))] = tbl[e][a];
    end
    for (int t = 0; t < T; t++)
      for (int s = 0; s < S; s++) img[XPO + t*S + s] = rowm[t][s];
  endfunction

  function automatic logic [S-1:0] one_src(input int s);
    return S'(1) << s;
  endfunction

  // mode 0: one source each, 1: mixed open/double, 2: directed fanout + ring
  function automatic void gen_config(input int mode);
    byp = N'($urandom);
    for (int e = 0; e < N; e++) tbl[e] = D'($urandom);
    for (int t = 0; t < T; t++) begin
      int s1, s2, r;
      s1 = int'($urandom % S);
      s2 = (s1 + 1 + int'($urandom % (S - 1))) % S;
      r  = int'($urandom % 10);
      rowm[t] = one_src(s1);
      if (mode == 1 && r < 2) rowm[t] = '0;
      if (mode == 1 && r > 7) rowm[t] = one_src(s1) | one_src(s2);
      if (mode == 2) begin
        if (t < T/2) rowm[t] = (t % K == 0) ? one_src(3) : one_src(I + (t / K + t % K) % N);
        else         rowm[t] = one_src(I + (t / K + 1) % N);
      end
    end
    if (mode == 2) begin
      rowm[1] = '0;
      rowm[2] = one_src(0) | one_src(I + 4);
    end
    build_img();
  endfunction

  task automatic load();
    cfg_en = 1;
    for (int i = W - 1; i >= 0; i--) begin
      cfg_din = img[i];
      clu_in = I'($urandom);
      #1;
      if (i == W/2 || i == 0) check(clu_out == '0, "R3 outputs quiet while loading", clu_out, 0);
      @(posedge clk); @(negedge clk);
    end
    cfg_en = 0;
    q_m = '0;
  endtask

  task automatic step();
    logic [N-1:0] lv; logic [T-1:0] cf;
    clu_in = I'($urandom);
    #1;
    model(lv, cf);
    for (int e = 0; e < N; e++) begin
      logic exp;
      exp = byp[e] ? lv[e] : q_m[e];
      if (byp[e]) check(clu_out[e] == exp, "R1 R2 R4 R5 comb element (R7)", clu_out[e], exp);
      else        check(clu_out[e] == exp, "R7 R8 registered element", clu_out[e], exp);
      if (was_rst && !byp[e]) check(clu_out[e] == 1'b0, "R9 flop cleared by reset", clu_out[e], 0);
    end
    check(xbar_conflict == cf, "R6 conflict flags", xbar_conflict, cf);
    was_rst = rst;
    @(posedge clk);
    q_m = rst ? '0 : lv;
    @(negedge clk);
  endtask

  task automatic run(input int cycles, input int rst_at);
    for (int c = 0; c < cycles; c++) begin
      rst = (c == rst_at);
      step();
    end
    rst = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    was_rst = 0;
    q_m = '0;
    #1;
    check(clu_out == '0, "R3 reset state outputs", clu_out, 0);
    @(negedge clk); @(negedge clk);
    rst = 0;
    gen_config(2); load(); run(150, 60);
    gen_config(0); load(); run(200, 100);
    gen_config(1); load(); run(200, 50);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule